// File: doc/BRIEF.md
# Loop Power-Down Sequencer

This block decides when one phase-locked loop of a dual-loop frequency synthesizer goes to sleep and how much of it sleeps. Each loop receives a power-down request bit and a charge-pump tri-state bit from the register file, and a busy flag from the phase detector. The busy flag is high while a charge-pump correction pulse is in flight. The top module holds one independent sequencer per loop, so one loop can keep running while the other is shut down.

When the tri-state bit is low, the sequencer waits for any pulse in flight to end before it powers down, and it shuts down only the charge pump. When the tri-state bit is high, it powers down on the next clock whatever the pulse state, and it shuts down the whole loop. In both cases the reference and feedback dividers are held in reset together. They are released together in the cycle after the request is withdrawn, so the two dividers restart from zero with a fixed phase relation.

Top module: `pdseq_dual`

## Requirements
- R1: A synchronous active-high reset puts every loop into the running state. In that state both divider holds are 0, `cp_enable` is 1, `loop_enable` is 1 and `pd_done` is 0.
- R2: While running or waiting, a request (`pd_req`=1) with `tri_sel`=0 and `pulse_busy`=1 leaves or puts the loop in the waiting state. In that state the outputs equal the running outputs, so the dividers keep counting and the charge pump stays enabled.
- R3: A request with `tri_sel`=0 and `pulse_busy`=0 gives the powered-down outputs after the next rising clock edge, whether the loop was running or waiting.
- R4: A request with `tri_sel`=1 gives the powered-down outputs after the next rising clock edge, whatever the value of `pulse_busy`.
- R5: The depth of shutdown is taken from `tri_sel` at the edge where the loop enters power-down. If it was 0, only the charge pump is off and `loop_enable` stays 1. If it was 1, `loop_enable` is 0. Changes of `tri_sel` while the loop is powered down do not alter `loop_enable`.
- R6: While powered down, `ref_cnt_hold` and `fb_cnt_hold` are both 1 and `cp_enable` is 0.
- R7: With `pd_req`=0 at a rising edge, the loop shows the running outputs after that edge, from any state. Both divider holds fall in the same cycle.
- R8: Each loop follows only its own input bits. Activity on one loop never changes the outputs of another.
- R9: `pd_done` is 1 exactly while the loop is in the powered-down state, never while waiting.
- R10: While waiting, a change of `tri_sel` to 1 with the request still set powers the loop down on the next edge, with the whole loop shut down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | NUM_LOOPS | Power-down request per loop |
| tri_sel | input | NUM_LOOPS | Charge-pump tri-state bit per loop; picks immediate and whole-loop shutdown when 1 |
| pulse_busy | input | NUM_LOOPS | High while a charge-pump pulse of that loop is in flight |
| ref_cnt_hold | output | NUM_LOOPS | Holds the reference divider in reset |
| fb_cnt_hold | output | NUM_LOOPS | Holds the feedback divider in reset |
| cp_enable | output | NUM_LOOPS | Charge-pump enable |
| loop_enable | output | NUM_LOOPS | Enable for the rest of the loop |
| pd_done | output | NUM_LOOPS | High while the loop is fully powered down |

## Verification
The bench drives a request with no pulse in flight, which tells whether the next-clock entry works. It drives a request during a pulse of several cycles, which separates waiting from premature shutdown. An immediate-mode request during a pulse shows that the pulse is ignored. Toggling `tri_sel` while waiting and while down separates a live scope from a latched one. Withdrawing the request from both the waiting and the down state checks that the divider holds fall together. It also drives opposite patterns on the two loops, and a long stretch of pseudo-random input bits. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    PD_ACTIVE     = 2'd0,
    PD_WAIT_PULSE = 2'd1,
    PD_DOWN       = 2'd2
  } pd_state_e;

  typedef struct packed {
    logic ref_hold;
    logic fb_hold;
    logic cp_en;
    logic loop_en;
    logic down;
  } pd_out_s;

  // Map a state and latched scope onto the loop control lines.
  function automatic pd_out_s pd_decode(pd_state_e st, logic whole);
    pd_out_s o;
    o.ref_hold = (st == PD_DOWN);
    o.fb_hold  = (st == PD_DOWN);
    o.cp_en    = (st != PD_DOWN);
    o.loop_en  = !((st == PD_DOWN) && whole);
    o.down     = (st == PD_DOWN);
    return o;
  endfunction

endpackage

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pd_req,
  input  logic      tri_sel,
  input  logic      pulse_busy,
  output pd_state_e state_nxt,
  output logic      whole_nxt
);

  pd_state_e state_q;
  logic      whole_q;
  logic      go_now;

  // Immediate entry: tri-state set, or nothing in flight to wait for.
  assign go_now = tri_sel || !pulse_busy;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      PD_ACTIVE: begin
        if (pd_req) state_nxt = go_now ? PD_DOWN : PD_WAIT_PULSE;
      end
      PD_WAIT_PULSE: begin
        if (!pd_req)     state_nxt = PD_ACTIVE;
        else if (go_now) state_nxt = PD_DOWN;
      end
      PD_DOWN: begin
        if (!pd_req) state_nxt = PD_ACTIVE;
      end
      default: state_nxt = PD_ACTIVE;
    endcase
  end

  // Scope is captured at the entry edge and held while down.
  always_comb begin
    if (state_nxt != PD_DOWN)      whole_nxt = 1'b0;
    else if (state_q != PD_DOWN)   whole_nxt = tri_sel;
    else                           whole_nxt = whole_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PD_ACTIVE;
      whole_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      whole_q <= whole_nxt;
    end
  end

endmodule

// File: rtl/pdseq_outreg.sv
module pdseq_outreg
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pd_state_e state_nxt,
  input  logic      whole_nxt,
  output logic      ref_hold,
  output logic      fb_hold,
  output logic      cp_en,
  output logic      loop_en,
  output logic      down
);

  pd_out_s out_q;

  always_ff @(posedge clk) begin
    if (rst) out_q <= pd_decode(PD_ACTIVE, 1'b0);
    else     out_q <= pd_decode(state_nxt, whole_nxt);
  end

  assign ref_hold = out_q.ref_hold;
  assign fb_hold  = out_q.fb_hold;
  assign cp_en    = out_q.cp_en;
  assign loop_en  = out_q.loop_en;
  assign down     = out_q.down;

endmodule

// File: rtl/pdseq_loop.sv
module pdseq_loop
  import pdseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic tri_sel,
  input  logic pulse_busy,
  output logic ref_hold,
  output logic fb_hold,
  output logic cp_en,
  output logic loop_en,
  output logic down
);

  pd_state_e state_nxt;
  logic      whole_nxt;

  pdseq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .pd_req     (pd_req),
    .tri_sel    (tri_sel),
    .pulse_busy (pulse_busy),
    .state_nxt  (state_nxt),
    .whole_nxt  (whole_nxt)
  );

  pdseq_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .whole_nxt (whole_nxt),
    .ref_hold  (ref_hold),
    .fb_hold   (fb_hold),
    .cp_en     (cp_en),
    .loop_en   (loop_en),
    .down      (down)
  );

  assert_wait_keeps_running_R2: assert property (@(posedge clk) disable iff (rst)
    pd_req && !tri_sel && pulse_busy && !down |=> !down && !ref_hold && !fb_hold && cp_en);

  assert_sync_entry_R3: assert property (@(posedge clk) disable iff (rst)
    pd_req && !tri_sel && !pulse_busy |=> down);

  assert_async_entry_R4: assert property (@(posedge clk) disable iff (rst)
    pd_req && tri_sel |=> down);

  assert_scope_at_entry_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(down) |-> (loop_en != $past(tri_sel)));

  assert_scope_held_R5: assert property (@(posedge clk) disable iff (rst)
    down && $past(down) |-> $stable(loop_en));

  assert_down_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    down |-> ref_hold && fb_hold && !cp_en);

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    !pd_req |=> !ref_hold && !fb_hold && cp_en && loop_en && !down);

endmodule

// File: rtl/pdseq_dual.sv
module pdseq_dual #(
  parameter int NUM_LOOPS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOOPS-1:0] pd_req,
  input  logic [NUM_LOOPS-1:0] tri_sel,
  input  logic [NUM_LOOPS-1:0] pulse_busy,
  output logic [NUM_LOOPS-1:0] ref_cnt_hold,
  output logic [NUM_LOOPS-1:0] fb_cnt_hold,
  output logic [NUM_LOOPS-1:0] cp_enable,
  output logic [NUM_LOOPS-1:0] loop_enable,
  output logic [NUM_LOOPS-1:0] pd_done
);

  // R8: every loop gets its own sequencer with no shared state.
  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    pdseq_loop u_loop (
      .clk        (clk),
      .rst        (rst),
      .pd_req     (pd_req[g]),
      .tri_sel    (tri_sel[g]),
      .pulse_busy (pulse_busy[g]),
      .ref_hold   (ref_cnt_hold[g]),
      .fb_hold    (fb_cnt_hold[g]),
      .cp_en      (cp_enable[g]),
      .loop_en    (loop_enable[g]),
      .down       (pd_done[g])
    );
  end

endmodule

// File: tb/test_pdseq_dual.sv
module test_pdseq_dual;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] pd_req = '0, tri_sel = '0, pulse_busy = '0;
  logic [NL-1:0] ref_cnt_hold, fb_cnt_hold, cp_enable, loop_enable, pd_done;

  int errors = 0;
  int checks = 0;
  bit chk_on = 1'b0;
  string cur_req = "R1";

  // behavioural model: 0 running, 1 waiting, 2 down
  int st [NL];
  bit wh [NL];

  always #10 clk = ~clk;

  pdseq_dual #(.NUM_LOOPS(NL)) i_pdseq_dual (
    .clk(clk), .rst(rst), .pd_req(pd_req), .tri_sel(tri_sel),
    .pulse_busy(pulse_busy), .ref_cnt_hold(ref_cnt_hold),
    .fb_cnt_hold(fb_cnt_hold), .cp_enable(cp_enable),
    .loop_enable(loop_enable), .pd_done(pd_done)
  );

  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (rst) begin
        st[l] = 0; wh[l] = 0;
      end else if (!pd_req[l]) begin
        st[l] = 0; wh[l] = 0;
      end else if (st[l] != 2) begin
        if (tri_sel[l] || !pulse_busy[l]) begin
          st[l] = 2; wh[l] = tri_sel[l];
        end else begin
          st[l] = 1;
        end
      end
    end
    chk_on = 1'b1;
  end

  task automatic cmp(string what, int l, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s loop%0d %s: actual=%b expected=%b at %0t",
               cur_req, l, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      for (int l = 0; l < NL; l++) begin
        cmp("ref_cnt_hold", l, ref_cnt_hold[l], st[l] == 2);
        cmp("fb_cnt_hold",  l, fb_cnt_hold[l],  st[l] == 2);
        cmp("cp_enable",    l, cp_enable[l],    st[l] != 2);
        cmp("loop_enable",  l, loop_enable[l],  !(st[l] == 2 && wh[l]));
        cmp("pd_done",      l, pd_done[l],      st[l] == 2);
      end
    end
  end

  task automatic drive(int l, bit rq, bit ts, bit bz, int n);
    @(negedge clk);
    pd_req[l] = rq; tri_sel[l] = ts; pulse_busy[l] = bz;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R3";                      // sync, no pulse
    drive(0, 1, 0, 0, 4);
    cur_req = "R7";
    drive(0, 0, 0, 0, 3);

    cur_req = "R2";                      // sync, pulse in flight
    drive(0, 1, 0, 1, 5);
    cur_req = "R9";
    drive(0, 1, 0, 0, 3);
    cur_req = "R5";                      // scope latched while down
    drive(0, 1, 1, 0, 3);
    drive(0, 1, 0, 1, 2);
    cur_req = "R7";
    drive(0, 0, 1, 1, 3);

    cur_req = "R4";                      // async ignores the pulse
    drive(0, 1, 1, 1, 4);
    cur_req = "R5";
    drive(0, 1, 0, 0, 3);
    drive(0, 0, 0, 0, 2);

    cur_req = "R10";                     // async override while waiting
    drive(0, 1, 0, 1, 3);
    drive(0, 1, 1, 1, 4);
    drive(0, 0, 0, 0, 2);

    cur_req = "R7";                      // abort from waiting
    drive(0, 1, 0, 1, 3);
    drive(0, 0, 0, 1, 3);

    cur_req = "R8";                      // opposite patterns on the loops
    drive(0, 1, 1, 0, 1);
    drive(1, 0, 1, 1, 4);
    drive(1, 1, 0, 1, 3);
    drive(1, 0, 0, 0, 2);
    drive(0, 0, 0, 0, 2);

    cur_req = "R6";                      // pseudo-random stretch
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        pd_req[l]     = ($urandom % 4) != 0;
        tri_sel[l]    = ($urandom % 3) == 0;
        pulse_busy[l] = ($urandom % 2) == 0;
      end
    end

    cur_req = "R1";                      // reset while down
    drive(0, 1, 1, 0, 1);
    drive(1, 1, 0, 0, 2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    pd_req = '0; tri_sel = '0; pulse_busy = '0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule